// File: doc/BRIEF.md
# USB Host Bus Reset and Speed Negotiation Controller

This block sits on the host side of a USB port and drives the control fields of a low-pin-count transceiver: transceiver select, termination select and operating mode. When a device attaches it reads the idle line state to tell a low-speed device from a full-speed one. A low-speed device is reported at once and its port settings are left as they are. A full-speed device starts a bus reset. The controller switches the transceiver to high-speed mode with termination off, which puts SE0 on the bus, and it selects the chirp operating mode.

During the reset the controller looks for a device chirp K. It accepts a K only after the K has held for an unbroken run of clock cycles. When an accepted K ends, the controller sends a one-cycle strobe that starts the host's own chirp train, and it declares high speed when the reset ends. If no K is accepted, SE0 stays on the bus for the whole reset and the device is declared full speed. Each time the three control fields change, a one-cycle request asks the surrounding logic to write them into the transceiver's function-control register. The reset length is counted in microsecond ticks. The K qualification window is counted in clock cycles.

Top module: `hsd_host_reset`

## Requirements
- R1: After reset the outputs are transceiver select 2'b01, termination 1, operating mode 2'b00, done 0, speed 2'b00, and no write request or chirp strobe.
- R2: At attach with line state 2'b10 (K, D- high), the speed is low (2'b01) and done is raised. No function-control write is requested and the control fields keep their idle values.
- R3: At attach with line state 2'b01 (J, D+ high), the controller enters reset with transceiver select 2'b00, termination 0 and operating mode 2'b10.
- R4: Attach with line state 2'b00 (SE0) or 2'b11 (SE1) starts nothing. Done stays 0 and the control fields stay idle.
- R5: The reset lasts RESET_US microsecond ticks, counted from its start, before done rises.
- R6: A device chirp K (line state 2'b10) is accepted only after CHIRP_QUAL_CYC consecutive clock cycles of K during reset. Any sample that is not K restarts the count.
- R7: If no K is accepted, SE0 is held until the reset ends. The speed is then full (2'b10), and the control fields return to 2'b01, 1, 2'b00.
- R8: When an accepted K ends, host_chirp_o pulses for exactly one cycle within two cycles, with SE0 settings still applied. At the end of reset the speed is high (2'b11) and the fields become 2'b00, 0, 2'b00.
- R9: The speed codes are 00 none, 01 low, 10 full and 11 high. Done and speed hold until attach drops, and then the block returns to the R1 state.
- R10: fctl_wr_o pulses for one cycle exactly in the first cycle in which any control field holds a new value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| attach_i | input | 1 | Device attached indication |
| line_state_i | input | 2 | Sampled bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| xcvr_sel_o | output | 2 | Transceiver select (00 high-speed, 01 full-speed) |
| term_sel_o | output | 1 | Termination select |
| op_mode_o | output | 2 | Operating mode (00 normal, 10 chirp) |
| fctl_wr_o | output | 1 | Request to write the function-control register |
| host_chirp_o | output | 1 | Start strobe for the host chirp train |
| speed_o | output | 2 | Detected speed code |
| done_o | output | 1 | Detection complete |

## Verification
Some properties are checked on every cycle. Each write request coincides with a change of the control fields, and every field change has its request. A chirp strobe is a single cycle and happens only while SE0 is driven. A low-speed result never leaves the idle settings. A done flag always carries a speed code. The K qualifier rises only after a K sample. Other behaviour can only be shown by the bench's attach scenarios: the speed result for each idle line state, the exact qualification boundary (one cycle short against exactly long enough), a K run broken by a single J, the length of the reset, and the settings after reset.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RESET  = 3'd1,
      ST_CHIRP  = 3'd2,
      ST_HOSTCH = 3'd3,
      ST_DONE   = 3'd4
   } state_e;

   typedef enum logic [1:0] {
      SPD_NONE = 2'b00,
      SPD_LOW  = 2'b01,
      SPD_FULL = 2'b10,
      SPD_HIGH = 2'b11
   } speed_e;

   localparam logic [1:0] LS_SE0 = 2'b00;
   localparam logic [1:0] LS_J   = 2'b01;
   localparam logic [1:0] LS_K   = 2'b10;

   typedef struct packed {
      logic [1:0] xcvr;
      logic       term;
      logic [1:0] opm;
   } ctrl_t;

   localparam ctrl_t CTRL_FS_IDLE = '{xcvr: 2'b01, term: 1'b1, opm: 2'b00};
   localparam ctrl_t CTRL_SE0     = '{xcvr: 2'b00, term: 1'b0, opm: 2'b10};
   localparam ctrl_t CTRL_HS_RUN  = '{xcvr: 2'b00, term: 1'b0, opm: 2'b00};
endpackage

// File: rtl/hsd_tick_timer.sv
module hsd_tick_timer #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic expire_o
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("hsd_tick_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end   = (cnt_q == CW'(LIMIT - 1));
   assign expire_o = run_i && tick_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i)           cnt_q <= '0;
      else if (tick_i && !at_end) cnt_q <= cnt_q + 1'b1;
   end

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(LIMIT));
   assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/hsd_chirp_qual.sv
module hsd_chirp_qual #(
   parameter int QUAL_CYC = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic is_k_i,
   output logic qual_o
);
   localparam int QW = $clog2(QUAL_CYC + 1);

   generate
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("hsd_chirp_qual: QUAL_CYC must be at least 2");
      end
   endgenerate

   logic [QW-1:0] run_q;

   assign qual_o = (run_q == QW'(QUAL_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (!(en_i && is_k_i)) run_q <= '0;
      else if (!qual_o)           run_q <= run_q + 1'b1;
   end

   assert_qual_after_k_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_o) |-> $past(en_i && is_k_i));
   assert_break_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_k_i |=> !qual_o);
endmodule

// File: rtl/hsd_host_reset.sv
module hsd_host_reset
   import hsd_pkg::*;
#(
   parameter int RESET_US       = 10000,
   parameter int CHIRP_QUAL_CYC = 150
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       attach_i,
   input  logic [1:0] line_state_i,
   input  logic       us_tick_i,
   output logic [1:0] xcvr_sel_o,
   output logic       term_sel_o,
   output logic [1:0] op_mode_o,
   output logic       fctl_wr_o,
   output logic       host_chirp_o,
   output logic [1:0] speed_o,
   output logic       done_o
);
   state_e state_q, state_d;
   speed_e speed_q, speed_d;
   logic   chirp_d, chirp_q, wr_q;
   logic   in_reset, expire, qual, is_k;
   ctrl_t  ctrl_now, ctrl_next;

   function automatic ctrl_t ctrl_of(state_e s, speed_e sp);
      ctrl_t c;
      case (s)
         ST_RESET, ST_CHIRP, ST_HOSTCH: c = CTRL_SE0;
         ST_DONE:  c = (sp == SPD_HIGH) ? CTRL_HS_RUN : CTRL_FS_IDLE;
         default:  c = CTRL_FS_IDLE;
      endcase
      return c;
   endfunction

   assign is_k     = (line_state_i == LS_K);
   assign in_reset = (state_q == ST_RESET) || (state_q == ST_CHIRP) ||
                     (state_q == ST_HOSTCH);

   hsd_tick_timer #(.LIMIT(RESET_US)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(in_reset),
      .tick_i(us_tick_i), .expire_o(expire)
   );

   hsd_chirp_qual #(.QUAL_CYC(CHIRP_QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_RESET),
      .is_k_i(is_k), .qual_o(qual)
   );

   always_comb begin
      state_d = state_q;
      speed_d = speed_q;
      chirp_d = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (attach_i && is_k) begin
               state_d = ST_DONE;
               speed_d = SPD_LOW;
            end else if (attach_i && (line_state_i == LS_J)) begin
               state_d = ST_RESET;
            end
         end
         ST_RESET: begin
            if (!attach_i)   state_d = ST_IDLE;
            else if (expire) begin
               state_d = ST_DONE;
               speed_d = SPD_FULL;
            end else if (qual) state_d = ST_CHIRP;
         end
         ST_CHIRP: begin
            if (!attach_i)   state_d = ST_IDLE;
            else if (expire) begin
               state_d = ST_DONE;
               speed_d = SPD_FULL;
            end else if (!is_k) begin
               state_d = ST_HOSTCH;
               chirp_d = 1'b1;
            end
         end
         ST_HOSTCH: begin
            if (!attach_i)   state_d = ST_IDLE;
            else if (expire) begin
               state_d = ST_DONE;
               speed_d = SPD_HIGH;
            end
         end
         ST_DONE: begin
            if (!attach_i) begin
               state_d = ST_IDLE;
               speed_d = SPD_NONE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (state_d == ST_IDLE) speed_d = SPD_NONE;
   end

   assign ctrl_now  = ctrl_of(state_q, speed_q);
   assign ctrl_next = ctrl_of(state_d, speed_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         speed_q <= SPD_NONE;
         chirp_q <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         speed_q <= speed_d;
         chirp_q <= chirp_d;
         wr_q    <= (ctrl_next != ctrl_now);
      end
   end

   assign xcvr_sel_o   = ctrl_now.xcvr;
   assign term_sel_o   = ctrl_now.term;
   assign op_mode_o    = ctrl_now.opm;
   assign fctl_wr_o    = wr_q;
   assign host_chirp_o = chirp_q;
   assign speed_o      = speed_q;
   assign done_o       = (state_q == ST_DONE);

   assert_done_has_speed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (speed_o != 2'b00));
   assert_low_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_o == 2'b01) |-> (xcvr_sel_o == 2'b01 && term_sel_o && op_mode_o == 2'b00));
   assert_chirp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_chirp_o |=> !host_chirp_o);
   assert_chirp_under_se0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_chirp_o |-> (xcvr_sel_o == 2'b00 && !term_sel_o && op_mode_o == 2'b10));
   assert_write_means_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fctl_wr_o |-> !$stable({xcvr_sel_o, term_sel_o, op_mode_o}));
   assert_change_means_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({xcvr_sel_o, term_sel_o, op_mode_o}) |-> fctl_wr_o);
endmodule

// File: tb/test_hsd_host_reset.sv
module test_hsd_host_reset;
   localparam int RST_US = 50;
   localparam int QUAL   = 10;
   localparam int TDIV   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       attach = 1'b0;
   logic [1:0] ls = 2'b01;
   logic       us_tick = 1'b0;
   logic [1:0] xcvr, opm, speed;
   logic       term, fwr, hchirp, done;

   int checks = 0, errs = 0, cyc = 0;

   hsd_host_reset #(.RESET_US(RST_US), .CHIRP_QUAL_CYC(QUAL)) i_hsd_host_reset (
      .clk(clk), .rst_n(rst_n), .attach_i(attach), .line_state_i(ls),
      .us_tick_i(us_tick), .xcvr_sel_o(xcvr), .term_sel_o(term),
      .op_mode_o(opm), .fctl_wr_o(fwr), .host_chirp_o(hchirp),
      .speed_o(speed), .done_o(done)
   );

   always #2 clk = ~clk;

   int tdiv = 0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
      us_tick <= (tdiv == TDIV - 1);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   typedef struct { logic [1:0] spd; int wr; bit timed; string req; } exp_t;
   exp_t exp_q[$];

   int  wr_cnt = 0, wr_start = -1;
   bit  prev_done = 1'b0;
   bit  chirp_seen = 1'b0;
   always @(negedge clk) begin
      if (fwr) begin
         if (wr_cnt == 0) wr_start = cyc;
         wr_cnt++;
      end
      if (hchirp) chirp_seen = 1'b1;
      if (done && !prev_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(speed == e.spd, e.req, "speed code", speed, e.spd);
            check(wr_cnt == e.wr, "R10", "write requests", wr_cnt, e.wr);
            if (e.timed)
               check((cyc - wr_start) >= RST_US*TDIV - TDIV &&
                     (cyc - wr_start) <= RST_US*TDIV + 2,
                     "R5", "reset length cycles", cyc - wr_start, RST_US*TDIV);
         end
      end
      prev_done = done;
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start(input logic [1:0] l, input logic [1:0] spd,
                        input int wr, input bit timed, input string req);
      exp_t e;
      e.spd = spd; e.wr = wr; e.timed = timed; e.req = req;
      exp_q.push_back(e);
      wr_cnt = 0; wr_start = -1; chirp_seen = 1'b0;
      ls = l; attach = 1'b1;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      check(done == 1'b1, req, "done reached", done, 1);
   endtask

   task automatic detach();
      attach = 1'b0; ls = 2'b01;
      cycles(3);
      check(done == 1'b0 && speed == 2'b00, "R9", "cleared after detach",
            {done, speed}, 0);
      check(xcvr == 2'b01 && term == 1'b1 && opm == 2'b00, "R1",
            "idle fields after detach", {xcvr, term, opm}, 5'b01100);
   endtask

   task automatic enter_reset();
      cycles(3);
      check(xcvr == 2'b00 && term == 1'b0 && opm == 2'b10, "R3",
            "SE0 chirp settings", {xcvr, term, opm}, 5'b00010);
      check(wr_cnt == 1, "R10", "write at reset start", wr_cnt, 1);
      ls = 2'b00;
   endtask

   initial begin : watchdog
      #400000;
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      cycles(3);
      check(xcvr == 2'b01 && term == 1'b1 && opm == 2'b00, "R1",
            "fields in reset", {xcvr, term, opm}, 5'b01100);
      check(done == 1'b0 && speed == 2'b00 && fwr == 1'b0 && hchirp == 1'b0,
            "R1", "flags in reset", {done, speed, fwr, hchirp}, 0);
      rst_n = 1'b1;
      cycles(3);

      // R4: SE0 and SE1 at attach start nothing
      ls = 2'b00; attach = 1'b1; cycles(20);
      check(done == 1'b0 && xcvr == 2'b01 && term == 1'b1, "R4",
            "SE0 attach ignored", {done, xcvr, term}, 3'b011);
      ls = 2'b11; cycles(20);
      check(done == 1'b0 && xcvr == 2'b01 && term == 1'b1 && wr_cnt == 0, "R4",
            "SE1 attach ignored", {done, xcvr, term}, 3'b011);
      attach = 1'b0; ls = 2'b01; cycles(3);

      // R2: low speed, no negotiation
      start(2'b10, 2'b01, 0, 1'b0, "R2");
      wait_done("R2");
      cycles(5);
      check(xcvr == 2'b01 && term == 1'b1 && opm == 2'b00, "R2",
            "low speed fields kept", {xcvr, term, opm}, 5'b01100);
      detach();

      // R7: full speed, no chirp at all
      start(2'b01, 2'b10, 2, 1'b1, "R7");
      enter_reset();
      wait_done("R7");
      check(xcvr == 2'b01 && term == 1'b1 && opm == 2'b00, "R7",
            "fields restored", {xcvr, term, opm}, 5'b01100);
      check(!chirp_seen, "R7", "no host chirp", chirp_seen, 0);
      detach();

      // R6: K one cycle short of qualifying
      start(2'b01, 2'b10, 2, 1'b1, "R6");
      enter_reset();
      cycles(5);
      ls = 2'b10; cycles(QUAL - 1); ls = 2'b00;
      cycles(5);
      check(!chirp_seen, "R6", "short K rejected", chirp_seen, 0);
      wait_done("R6");
      detach();

      // R6: K broken by one J sample
      start(2'b01, 2'b10, 2, 1'b1, "R6");
      enter_reset();
      ls = 2'b10; cycles(QUAL - 3); ls = 2'b01; cycles(1);
      ls = 2'b10; cycles(QUAL - 3); ls = 2'b00;
      cycles(5);
      check(!chirp_seen, "R6", "broken K rejected", chirp_seen, 0);
      wait_done("R6");
      detach();

      // R8: K exactly long enough -> host chirp, high speed
      start(2'b01, 2'b11, 2, 1'b1, "R8");
      enter_reset();
      cycles(5);
      ls = 2'b10; cycles(QUAL); ls = 2'b00;
      check(!chirp_seen, "R8", "no strobe during K", chirp_seen, 0);
      cycles(3);
      check(chirp_seen, "R8", "strobe after K end", chirp_seen, 1);
      check(xcvr == 2'b00 && term == 1'b0 && opm == 2'b10, "R8",
            "SE0 kept during host chirp", {xcvr, term, opm}, 5'b00010);
      wait_done("R8");
      check(xcvr == 2'b00 && term == 1'b0 && opm == 2'b00, "R8",
            "high speed fields", {xcvr, term, opm}, 5'b00000);
      cycles(10);
      check(done == 1'b1 && speed == 2'b11, "R9", "result held",
            {done, speed}, 3'b111);
      detach();
      check(wr_cnt == 3, "R10", "write on return to idle", wr_cnt, 3);

      cycles(5);
      check(exp_q.size() == 0, "R9", "all results seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule